// File: doc/BRIEF.md
# Read-Side Width Adapter for a 36-bit FIFO

This block sits between the output of a FIFO holding 36-bit long words and a read port whose width is chosen at reset. The read port can be 36 bits wide, 18 bits wide or 9 bits wide. In 36-bit mode each transfer carries one whole stored word. In 18-bit mode a stored word is delivered as two transfers. In 9-bit mode it is delivered as four transfers. For the two narrow sizes, a second setting picks whether the most significant slice or the least significant slice goes out first.

The adapter takes a word from a show-ahead FIFO into a holding register. It keeps a slice index for that word and signals `rd_ready` while the held word still has unread slices. It asks the FIFO for the next word only when the final slice of the current word is accepted. If a word is already waiting, the reload happens on that same clock edge, so back-to-back reads lose no cycle.

Both settings are sampled while the full reset is active. A partial reset drops the held word and the slice index but keeps both settings. The write side of the FIFO is always 36 bits wide and is not part of this block.

Top module: `bus_match_rd`

## Requirements
- R1: When `cfg_size` was 2'b00 during full reset, each accepted read delivers the entire held 36-bit word on `rd_data` and consumes one FIFO word. The value 2'b11 is treated the same way.
- R2: When `cfg_size` was 2'b01 during full reset, each held word is delivered as two 18-bit slices on `rd_data[17:0]`, and `rd_data[35:18]` reads zero.
- R3: When `cfg_size` was 2'b10 during full reset, each held word is delivered as four 9-bit slices on `rd_data[8:0]`, and `rd_data[35:9]` reads zero.
- R4: When `cfg_big_end` was 1 during full reset, slices go out from the most significant (bits 35 downward) to the least significant. When it was 0, slices go out from the least significant (bits 8:0 or 17:0) upward.
- R5: `cfg_size` and `cfg_big_end` are captured on every clock edge while `rst_n` is low. Changes to them while `rst_n` is high, including across a partial reset, have no effect.
- R6: `fifo_pop` is high only when `fifo_empty` is low and one of two conditions holds: no word is held, or the final slice of the held word is being accepted. The popped word is presented with `rd_ready` high in the next cycle, starting from its first slice.
- R7: `rd_ready` stays high, and `rd_data` stays unchanged, while unread slices of the held word remain and no read is accepted, even if the FIFO is empty. After the final slice is accepted with the FIFO empty, `rd_ready` goes low.
- R8: A read is accepted only when `rd_en` and `rd_ready` are both high in the same cycle. `rd_en` while `rd_ready` is low neither pops the FIFO nor advances the slice order.
- R9: `prst_n` low at a clock edge discards the held word and the slice index, so `rd_ready` is low in the next cycle. The next word then starts from its first slice.
- R10: After full reset, with the FIFO empty, `rd_ready` and `fifo_pop` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full reset, active low, synchronous; settings are sampled while it is low |
| prst_n | input | 1 | Partial reset, active low, synchronous; clears the held word, keeps the settings |
| cfg_size | input | 2 | Read width: 00 = 36 bits, 01 = 18 bits, 10 = 9 bits, 11 = 36 bits |
| cfg_big_end | input | 1 | 1 = most significant slice first, 0 = least significant slice first |
| fifo_data | input | 36 | Head word of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Removes the head word from the FIFO at this edge |
| rd_en | input | 1 | The reader takes the current transfer |
| rd_ready | output | 1 | A transfer is available on `rd_data` |
| rd_data | output | 36 | Current transfer, right-aligned, with unused upper bits at zero |

## Verification
The hardest case to reach is the edge where the final slice of one word is accepted while the next word is already waiting in the FIFO. At that edge the adapter must pop, reload the holding register and reset the slice index, all at once. The bench reaches this case by queuing two words before reading any slice. It then checks the pop count just before and just after the fourth read, and checks that the next word's first slice appears with no gap.

A partial reset taken halfway through a word, with the settings inputs already changed, is reached in a similar way. The bench reads one slice, changes the settings inputs, pulses `prst_n`, and then checks that the following word is sliced with the old settings, starting from its first slice.

// File: rtl/bm_pkg.sv
package bm_pkg;
   typedef enum logic [1:0] {
      BM_W36 = 2'b00,
      BM_W18 = 2'b01,
      BM_W9  = 2'b10
   } bm_size_e;

   // index of the final slice of a held word for each read width
   function automatic logic [1:0] bm_last_idx(bm_size_e s);
      case (s)
         BM_W18:  return 2'd1;
         BM_W9:   return 2'd3;
         default: return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/bm_cfg_reg.sv
module bm_cfg_reg
   import bm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] size_in,
   input  logic       be_in,
   output bm_size_e   size_q,
   output logic       be_q
);
   bm_size_e size_dec;

   // the reserved code falls back to full width
   always_comb begin
      case (size_in)
         2'b01:   size_dec = BM_W18;
         2'b10:   size_dec = BM_W9;
         default: size_dec = BM_W36;
      endcase
   end

   // settings follow the inputs only while full reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_q <= size_dec;
         be_q   <= be_in;
      end
   end
endmodule

// File: rtl/bm_hold_ctrl.sv
module bm_hold_ctrl
   import bm_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prst_n,
   input  bm_size_e          size_q,
   input  logic [WORD_W-1:0] fifo_data,
   input  logic              fifo_empty,
   input  logic              rd_en,
   output logic              fifo_pop,
   output logic [WORD_W-1:0] hold_word,
   output logic              hold_valid,
   output logic [1:0]        slice_idx
);
   logic clr;
   logic accept;
   logic last;
   logic load;

   assign clr    = !rst_n || !prst_n;
   assign accept = rd_en && hold_valid;
   assign last   = (slice_idx == bm_last_idx(size_q));
   assign load   = !clr && !fifo_empty && (!hold_valid || (accept && last));

   assign fifo_pop = load;

   always_ff @(posedge clk) begin
      if (clr) begin
         hold_word  <= '0;
         hold_valid <= 1'b0;
         slice_idx  <= 2'd0;
      end else if (load) begin
         hold_word  <= fifo_data;
         hold_valid <= 1'b1;
         slice_idx  <= 2'd0;
      end else if (accept && last) begin
         hold_valid <= 1'b0;
         slice_idx  <= 2'd0;
      end else if (accept) begin
         slice_idx  <= slice_idx + 2'd1;
      end
   end
endmodule

// File: rtl/bm_slice_sel.sv
module bm_slice_sel
   import bm_pkg::*;
#(
   parameter int SLICE_W = 9
) (
   input  logic [4*SLICE_W-1:0] hold_word,
   input  bm_size_e             size_q,
   input  logic                 be_q,
   input  logic [1:0]           slice_idx,
   output logic [4*SLICE_W-1:0] rd_data
);
   localparam int WORD_W = 4 * SLICE_W;
   localparam int HALF_W = 2 * SLICE_W;

   logic [SLICE_W-1:0] qtr [4];
   logic [HALF_W-1:0]  hlf [2];
   logic [1:0]         phys;

   for (genvar q = 0; q < 4; q++) begin : g_qtr
      assign qtr[q] = hold_word[q*SLICE_W +: SLICE_W];
   end
   for (genvar h = 0; h < 2; h++) begin : g_hlf
      assign hlf[h] = hold_word[h*HALF_W +: HALF_W];
   end

   // big-endian walks lanes downward from the top slice
   assign phys = be_q ? (bm_last_idx(size_q) - slice_idx) : slice_idx;

   always_comb begin
      rd_data = '0;
      case (size_q)
         BM_W18:  rd_data[HALF_W-1:0]  = hlf[phys[0]];
         BM_W9:   rd_data[SLICE_W-1:0] = qtr[phys];
         default: rd_data              = hold_word;
      endcase
   end

   if (WORD_W != 4 * SLICE_W) begin : g_bad_w
      $error("bm_slice_sel: word width mismatch");
   end
endmodule

// File: rtl/bus_match_rd.sv
module bus_match_rd
   import bm_pkg::*;
#(
   parameter int SLICE_W = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 prst_n,
   input  logic [1:0]           cfg_size,
   input  logic                 cfg_big_end,
   input  logic [4*SLICE_W-1:0] fifo_data,
   input  logic                 fifo_empty,
   output logic                 fifo_pop,
   input  logic                 rd_en,
   output logic                 rd_ready,
   output logic [4*SLICE_W-1:0] rd_data
);
   localparam int WORD_W = 4 * SLICE_W;

   if (SLICE_W < 1) begin : g_bad_slice
      $error("bus_match_rd: SLICE_W must be at least 1");
   end

   bm_size_e          size_q;
   logic              be_q;
   logic [WORD_W-1:0] hold_word;
   logic              hold_valid;
   logic [1:0]        slice_idx;

   bm_cfg_reg i_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .size_in (cfg_size),
      .be_in   (cfg_big_end),
      .size_q  (size_q),
      .be_q    (be_q)
   );

   bm_hold_ctrl #(.WORD_W(WORD_W)) i_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .prst_n     (prst_n),
      .size_q     (size_q),
      .fifo_data  (fifo_data),
      .fifo_empty (fifo_empty),
      .rd_en      (rd_en),
      .fifo_pop   (fifo_pop),
      .hold_word  (hold_word),
      .hold_valid (hold_valid),
      .slice_idx  (slice_idx)
   );

   bm_slice_sel #(.SLICE_W(SLICE_W)) i_sel (
      .hold_word (hold_word),
      .size_q    (size_q),
      .be_q      (be_q),
      .slice_idx (slice_idx),
      .rd_data   (rd_data)
   );

   assign rd_ready = hold_valid;
endmodule

// File: rtl/bm_rd_chk.sv
module bm_rd_chk
   import bm_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prst_n,
   input logic              fifo_empty,
   input logic              fifo_pop,
   input logic              rd_en,
   input logic              rd_ready,
   input logic [WORD_W-1:0] rd_data,
   input bm_size_e          size_q
);
   localparam int HALF_W = WORD_W / 2;
   localparam int QTR_W  = WORD_W / 4;

   AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty); // R6
   AST_POP_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
      fifo_pop |=> rd_ready); // R6
   AST_NO_POP_MIDWORD: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && rd_ready) |-> rd_en); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
      (rd_ready && !rd_en) |=> (rd_ready && $stable(rd_data))); // R7
   AST_PRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !prst_n |=> !rd_ready); // R9
   AST_CFG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(size_q)); // R5
   AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (size_q == BM_W18) |-> (rd_data[WORD_W-1:HALF_W] == '0)); // R2
   AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (size_q == BM_W9) |-> (rd_data[WORD_W-1:QTR_W] == '0)); // R3
endmodule

bind bus_match_rd bm_rd_chk #(.WORD_W(WORD_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .prst_n     (prst_n),
   .fifo_empty (fifo_empty),
   .fifo_pop   (fifo_pop),
   .rd_en      (rd_en),
   .rd_ready   (rd_ready),
   .rd_data    (rd_data),
   .size_q     (size_q)
);

// File: tb/test_bus_match_rd.sv
module test_bus_match_rd;
   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC = 7;

   localparam logic [1:0]  V_SIZE [NVEC] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11};
   localparam logic        V_BE   [NVEC] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
   localparam logic [35:0] V_WORD [NVEC] = '{36'h9_A5C3_1E77, 36'h1_2345_6789, 36'hF_0F0F_1234,
                                              36'hA_BCDE_F012, 36'h8_0402_0100, 36'h5_5AA5_3CC3,
                                              36'h7_7654_3210};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prst_n = 1'b1;
   logic [1:0]  cfg_size = 2'b00;
   logic        cfg_big_end = 1'b0;
   logic [35:0] fifo_data;
   logic        fifo_empty;
   logic        fifo_pop;
   logic        rd_en = 1'b0;
   logic        rd_ready;
   logic [35:0] rd_data;

   logic [35:0] mem [16];
   int unsigned wp = 0;
   int unsigned rp = 0;
   int unsigned pops = 0;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign fifo_empty = (wp == rp);
   assign fifo_data  = mem[rp[3:0]];

   always @(posedge clk) begin
      if (fifo_pop) begin
         rp   <= rp + 1;
         pops <= pops + 1;
      end
   end

   bus_match_rd i_bus_match_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .prst_n      (prst_n),
      .cfg_size    (cfg_size),
      .cfg_big_end (cfg_big_end),
      .fifo_data   (fifo_data),
      .fifo_empty  (fifo_empty),
      .fifo_pop    (fifo_pop),
      .rd_en       (rd_en),
      .rd_ready    (rd_ready),
      .rd_data     (rd_data)
   );

   function automatic logic [35:0] exp_slice(logic [1:0] sz, logic be, logic [35:0] w, int k);
      int n;
      int wd;
      int p;
      logic [35:0] m;
      n  = (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
      wd = 36 / n;
      p  = be ? (n - 1 - k) : k;
      m  = (wd == 36) ? {36{1'b1}} : ((36'd1 << wd) - 36'd1);
      return (w >> (p * wd)) & m;
   endfunction

   function automatic int n_slices(logic [1:0] sz);
      return (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
   endfunction

   task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   task automatic full_reset(input logic [1:0] sz, input logic be);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_size = sz;
      cfg_big_end = be;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic push(input logic [35:0] w);
      mem[wp[3:0]] = w;
      wp = wp + 1;
   endtask

   // wait for a transfer, check it, then accept it
   task automatic read_one(input string tag, input logic [35:0] exp);
      int tries = 0;
      while (!rd_ready && tries < 8) begin
         @(negedge clk);
         tries++;
      end
      chk({tag, " ready"}, {35'd0, rd_ready}, 36'd1);
      chk({tag, " data"}, rd_data, exp);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [35:0] w1;
      logic [35:0] w2;
      int          p0;

      // R10 reset state
      full_reset(2'b10, 1'b1);
      chk("R10 ready after reset", {35'd0, rd_ready}, 36'd0);
      chk("R10 pop after reset", {35'd0, fifo_pop}, 36'd0);

      // table walk: R1 R2 R3 R4
      for (int v = 0; v < NVEC; v++) begin
         full_reset(V_SIZE[v], V_BE[v]);
         p0 = pops;
         push(V_WORD[v]);
         for (int k = 0; k < n_slices(V_SIZE[v]); k++) begin
            read_one($sformatf("R1/R2/R3/R4 vec%0d slice%0d", v, k),
                     exp_slice(V_SIZE[v], V_BE[v], V_WORD[v], k));
         end
         chk($sformatf("R6 vec%0d one pop per word", v), 36'(pops - p0), 36'd1);
         chk($sformatf("R7 vec%0d ready low when drained", v), {35'd0, rd_ready}, 36'd0);
      end

      // R6 back-to-back reload on the final slice, 9-bit big-endian
      full_reset(2'b10, 1'b1);
      w1 = 36'h1_8844_2211;
      w2 = 36'hE_1357_9BDF;
      p0 = pops;
      push(w1);
      push(w2);
      for (int k = 0; k < 3; k++) read_one("R3 b2b first word", exp_slice(2'b10, 1'b1, w1, k));
      chk("R6 no pop mid-word", 36'(pops - p0), 36'd1);
      read_one("R3 b2b last slice", exp_slice(2'b10, 1'b1, w1, 3));
      chk("R6 pop on last slice", 36'(pops - p0), 36'd2);
      chk("R6 next word ready at once", {35'd0, rd_ready}, 36'd1);
      chk("R6 next word first slice", rd_data, exp_slice(2'b10, 1'b1, w2, 0));
      for (int k = 0; k < 4; k++) read_one("R4 b2b second word", exp_slice(2'b10, 1'b1, w2, k));
      chk("R7 ready drops when fifo empty", {35'd0, rd_ready}, 36'd0);

      // R7 ready held with an empty FIFO, 18-bit little-endian
      full_reset(2'b01, 1'b0);
      w1 = 36'h3_C0DE_BEEF;
      push(w1);
      read_one("R2 hold first half", exp_slice(2'b01, 1'b0, w1, 0));
      repeat (5) @(negedge clk);
      chk("R7 ready held while slice remains", {35'd0, rd_ready}, 36'd1);
      chk("R7 data held while idle", rd_data, exp_slice(2'b01, 1'b0, w1, 1));
      read_one("R2 hold second half", exp_slice(2'b01, 1'b0, w1, 1));

      // R8 rd_en ignored while not ready
      p0 = pops;
      rd_en = 1'b1;
      repeat (4) @(negedge clk);
      rd_en = 1'b0;
      chk("R8 no pop while empty", 36'(pops - p0), 36'd0);
      chk("R8 not ready", {35'd0, rd_ready}, 36'd0);
      w1 = 36'h2_4681_3579;
      push(w1);
      read_one("R8 order not advanced", exp_slice(2'b01, 1'b0, w1, 0));
      read_one("R8 second half", exp_slice(2'b01, 1'b0, w1, 1));

      // R9 partial reset mid-word; R5 settings kept
      full_reset(2'b10, 1'b0);
      w1 = 36'hB_0000_FFFF;
      push(w1);
      read_one("R9 before partial reset", exp_slice(2'b10, 1'b0, w1, 0));
      cfg_size = 2'b00;
      cfg_big_end = 1'b1;
      prst_n = 1'b0;
      @(negedge clk);
      prst_n = 1'b1;
      chk("R9 ready cleared", {35'd0, rd_ready}, 36'd0);
      w2 = 36'h6_ABCD_0123;
      push(w2);
      for (int k = 0; k < 4; k++) read_one("R5/R9 after partial reset", exp_slice(2'b10, 1'b0, w2, k));
      chk("R5 no extra transfer", {35'd0, rd_ready}, 36'd0);

      finish_run();
   end
endmodule